// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Soft-Break

This block sits beside a small CPU core and decides which interrupt the core takes next. Sixteen hardware request lines and one software break strobe feed it. Each hardware request is held as pending until it is granted or cleared by software. Two 8-bit enable registers mask the sources individually, and a master enable flag gates all of the hardware sources at once. Each hardware source has a fixed 2-bit level. A higher level wins. Among sources at the same level, the lowest index wins.

When the core signals that it can take an interrupt, the block grants one request for a single cycle. With the grant it presents the source index and a 16-bit vector address. The break request has its own pending bit. It has the lowest priority, it cannot be masked, and its vector is the one used by table-call entry 0. A status flag records whether the last accept was a break, so the shared entry code can tell a break from a table call.

Every accept clears the master enable and pushes its previous value onto a small stack. The return-from-interrupt strobe pops that value back. A handler that sets the master enable again opens the way for nested service.

Top module: `brk_intc`

## Requirements
- R1: After reset, no source is pending, both enable registers are 0, the master enable and the break flag are 0, and `grant_o` stays 0 even while `cpu_ready_i` is high.
- R2: A pulse on `irq_i[i]` leaves source i pending until it is granted or until `pend_clr_i[i]` is pulsed. A masked pending source is not lost: once it is enabled, it is granted.
- R3: Source i has level `LEVELS[2i+1:2i]`, and among eligible sources the one with the highest level is granted. The default levels, for sources 0 to 15, are 1,1,2,0,3,0,2,1,0,0,1,0,0,0,0,3.
- R4: Among eligible sources that share the highest level, the one with the lowest index is granted.
- R5: The break request is granted only when no hardware source is eligible. It is granted with index 16 and vector `BRK_VEC` (default 16'hFFA0).
- R6: A hardware grant of source i carries index i and vector `HW_VEC_BASE + 2*i` (default base 16'hFFC0).
- R7: Every grant sets `b_flag_o` in the next cycle: to 1 for a break grant and to 0 for a hardware grant. A pulse on `tcall_i` clears it to 0.
- R8: A grant clears the master enable in the next cycle. No hardware source is granted while the master enable is 0.
- R9: If `me_set_i` sets the master enable again inside a handler, a pending enabled source is granted over the handler still in service.
- R10: On each grant, the previous master enable value is pushed onto a stack `NEST_DEPTH` deep. A `reti_i` pulse pops the most recent value back into the master enable.
- R11: A write with `en_wr_i` loads `en_data_i` into the low enable register (sources 0 to 7) when `en_hi_i` is 0, and into the high register (sources 8 to 15) when it is 1. A source whose enable bit is 0 is not granted.
- R12: A pending break is granted even while the master enable is 0.
- R13: `grant_o` is asserted only while `cpu_ready_i` is high. The granted source stops being pending, so the next ready does not grant it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 16 | Hardware request strobes, one per source |
| pend_clr_i | input | 16 | Software clear of pending bits |
| en_wr_i | input | 1 | Enable register write strobe |
| en_hi_i | input | 1 | Selects the high (1) or low (0) enable register |
| en_data_i | input | 8 | Enable register write data |
| me_set_i | input | 1 | Sets the master enable |
| me_clr_i | input | 1 | Clears the master enable |
| brk_i | input | 1 | Software break strobe |
| tcall_i | input | 1 | Table-call-0 strobe, clears the break flag |
| cpu_ready_i | input | 1 | Core can accept an interrupt this cycle |
| reti_i | input | 1 | Return-from-interrupt strobe |
| grant_o | output | 1 | One-cycle accept of the selected request |
| grant_idx_o | output | 5 | Granted source, where 16 means break |
| grant_vec_o | output | 16 | Vector address of the granted request |
| me_o | output | 1 | Master enable flag |
| b_flag_o | output | 1 | Break flag of the status word |

## Verification
The bench builds the block with its default parameters: two 8-bit enable registers, a nesting stack of depth 4, and a level table that sets all four levels across both registers. With that table, the bench can make a low-index source lose to a higher-level one, break ties within level 1 and level 3, and set a high-register source against a low-register source. Nesting a hardware grant inside a break handler, two levels deep, puts different values on the stack, so the order of the pops can be observed on `me_o`.

// File: rtl/pic_pkg.sv
// Shared constants and helpers for the interrupt controller.
// Assumes hardware vectors are 16-bit and spaced two bytes apart.
package pic_pkg;
    localparam int LVL_W = 2;
    localparam int VEC_W = 16;

    // Vector address of hardware source idx above the given base.
    function automatic logic [VEC_W-1:0] hw_vec(input logic [VEC_W-1:0] base,
                                                input logic [7:0] idx);
        return base + VEC_W'({idx, 1'b0});
    endfunction
endpackage

// File: rtl/pic_pending.sv
// Pending latch: one sticky bit per request line.
// Assumes a set arriving in the same cycle as a clear wins over the clear.
module pic_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold, set or clear one pending bit.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_q[i] <= 1'b0;
            else if (set_i[i]) pend_q[i] <= 1'b1;
            else if (clr_i[i]) pend_q[i] <= 1'b0;
        end

        AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[i] && !clr_i[i] |=> pend_q[i]); // R2
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pic_arbiter.sv
// Fixed-level priority selector: the highest level wins, and the lowest index breaks ties.
// Assumes LEVELS packs LVL_W bits per source, with source 0 in the low bits.
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int                 N      = 16,
    parameter logic [LVL_W*N-1:0] LEVELS = '0,
    localparam int                SEL_W  = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [SEL_W-1:0] sel_o
);
    logic [LVL_W-1:0] best_lvl;

    // Scan upward, and replace the winner only when the level is strictly higher.
    always_comb begin
        hit_o    = 1'b0;
        sel_o    = '0;
        best_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!hit_o || LEVELS[LVL_W*i +: LVL_W] > best_lvl)) begin
                hit_o    = 1'b1;
                best_lvl = LEVELS[LVL_W*i +: LVL_W];
                sel_o    = SEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_status.sv
// Master enable with a save stack, and the break flag of the status word.
// Assumes DEPTH >= 2. A push beyond DEPTH loses the oldest entry, and a pop from an empty stack yields 0.
module pic_status #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic brk_acc_i,
    input  logic reti_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic tcall_i,
    output logic me_o,
    output logic b_o
);
    logic             me_q;
    logic             b_q;
    logic [DEPTH-1:0] stk_q;

    // Master enable and stack: an accept has priority over a return, which has priority over software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            me_q  <= 1'b0;
            stk_q <= '0;
        end else if (accept_i) begin
            me_q  <= 1'b0;
            stk_q <= {stk_q[DEPTH-2:0], me_q};
        end else if (reti_i) begin
            me_q  <= stk_q[0];
            stk_q <= {1'b0, stk_q[DEPTH-1:1]};
        end else if (set_i) begin
            me_q  <= 1'b1;
        end else if (clr_i) begin
            me_q  <= 1'b0;
        end
    end

    // Break flag: loaded on every accept, cleared by a table call.
    always_ff @(posedge clk) begin
        if (!rst_n)        b_q <= 1'b0;
        else if (accept_i) b_q <= brk_acc_i;
        else if (tcall_i)  b_q <= 1'b0;
    end

    AST_ACCEPT_CLEARS_ME: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !me_q); // R8
    AST_ACCEPT_SAVES_ME: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> stk_q[0] == $past(me_q)); // R10
    AST_BRK_SETS_B: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && brk_acc_i |=> b_q); // R7

    assign me_o = me_q;
    assign b_o  = b_q;
endmodule

// File: rtl/brk_intc.sv
// Top level of the interrupt controller: enable registers, pending latches,
// arbitration, grant and vector output, and master enable and break flag handling.
// Assumes cpu_ready_i marks an instruction boundary, and that the core takes the
// grant in the same cycle it is offered.
module brk_intc
    import pic_pkg::*;
#(
    parameter int                        EN_W        = 8,
    parameter int                        NEST_DEPTH  = 4,
    parameter logic [2*LVL_W*EN_W-1:0]   LEVELS      = 32'hC010_6325,
    parameter logic [VEC_W-1:0]          HW_VEC_BASE = 16'hFFC0,
    parameter logic [VEC_W-1:0]          BRK_VEC     = 16'hFFA0,
    localparam int                       N_SRC       = 2 * EN_W,
    localparam int                       SEL_W       = $clog2(N_SRC),
    localparam int                       IDX_W       = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_i,
    input  logic [N_SRC-1:0] pend_clr_i,
    input  logic             en_wr_i,
    input  logic             en_hi_i,
    input  logic [EN_W-1:0]  en_data_i,
    input  logic             me_set_i,
    input  logic             me_clr_i,
    input  logic             brk_i,
    input  logic             tcall_i,
    input  logic             cpu_ready_i,
    input  logic             reti_i,
    output logic             grant_o,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic [VEC_W-1:0] grant_vec_o,
    output logic             me_o,
    output logic             b_flag_o
);
    logic [EN_W-1:0]  en_lo_q, en_hi_q;
    logic [N_SRC-1:0] en_all, pend, eligible, grant_clr;
    logic             brk_pend, hw_hit, brk_take, hw_take;
    logic [SEL_W-1:0] arb_sel;

    // Enable registers, written one half at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lo_q <= '0;
            en_hi_q <= '0;
        end else if (en_wr_i) begin
            if (en_hi_i) en_hi_q <= en_data_i;
            else         en_lo_q <= en_data_i;
        end
    end

    assign en_all   = {en_hi_q, en_lo_q};
    assign eligible = pend & en_all & {N_SRC{me_o}};

    pic_pending #(.N(N_SRC)) u_hw_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_i),
        .clr_i  (pend_clr_i | grant_clr),
        .pend_o (pend)
    );

    pic_pending #(.N(1)) u_brk_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (brk_i),
        .clr_i  (brk_take),
        .pend_o (brk_pend)
    );

    pic_arbiter #(.N(N_SRC), .LEVELS(LEVELS)) u_arb (
        .req_i (eligible),
        .hit_o (hw_hit),
        .sel_o (arb_sel)
    );

    assign hw_take  = cpu_ready_i && hw_hit;
    assign brk_take = cpu_ready_i && !hw_hit && brk_pend;
    assign grant_o  = hw_take || brk_take;

    // Pending clear mask for the source being granted.
    always_comb begin
        grant_clr = '0;
        if (hw_take) grant_clr[arb_sel] = 1'b1;
    end

    // Index and vector of the selected request; break takes the shared table-call vector.
    always_comb begin
        if (hw_hit) begin
            grant_idx_o = IDX_W'(arb_sel);
            grant_vec_o = hw_vec(HW_VEC_BASE, 8'(arb_sel));
        end else begin
            grant_idx_o = IDX_W'(N_SRC);
            grant_vec_o = BRK_VEC;
        end
    end

    pic_status #(.DEPTH(NEST_DEPTH)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (grant_o),
        .brk_acc_i (brk_take),
        .reti_i    (reti_i),
        .set_i     (me_set_i),
        .clr_i     (me_clr_i),
        .tcall_i   (tcall_i),
        .me_o      (me_o),
        .b_o       (b_flag_o)
    );

    AST_BRK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o && grant_idx_o == IDX_W'(N_SRC) |-> !(me_o && |(pend & en_all))); // R5
    AST_HW_GRANT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        hw_take |-> me_o && pend[arb_sel] && en_all[arb_sel]); // R11
    AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> cpu_ready_i); // R13
    AST_GRANTED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        hw_take && !irq_i[arb_sel] |=> !pend[$past(arb_sel)]); // R13
endmodule

// File: tb/brk_intc_tb.sv
`timescale 1ns/1ps
module brk_intc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_i = '0, pend_clr_i = '0;
    logic        en_wr_i = 0, en_hi_i = 0;
    logic [7:0]  en_data_i = '0;
    logic        me_set_i = 0, me_clr_i = 0, brk_i = 0, tcall_i = 0;
    logic        cpu_ready_i = 0, reti_i = 0;
    logic        grant_o, me_o, b_flag_o;
    logic [4:0]  grant_idx_o;
    logic [15:0] grant_vec_o;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    brk_intc u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .pend_clr_i(pend_clr_i),
        .en_wr_i(en_wr_i), .en_hi_i(en_hi_i), .en_data_i(en_data_i),
        .me_set_i(me_set_i), .me_clr_i(me_clr_i), .brk_i(brk_i), .tcall_i(tcall_i),
        .cpu_ready_i(cpu_ready_i), .reti_i(reti_i), .grant_o(grant_o),
        .grant_idx_o(grant_idx_o), .grant_vec_o(grant_vec_o), .me_o(me_o),
        .b_flag_o(b_flag_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All helpers start and end on a falling edge.
    task automatic raise(input logic [15:0] m);
        irq_i = m; @(negedge clk); irq_i = '0;
    endtask
    task automatic en_write(input bit hi, input logic [7:0] d);
        en_wr_i = 1; en_hi_i = hi; en_data_i = d; @(negedge clk); en_wr_i = 0;
    endtask
    task automatic me_set();  me_set_i = 1; @(negedge clk); me_set_i = 0; endtask
    task automatic me_clr();  me_clr_i = 1; @(negedge clk); me_clr_i = 0; endtask
    task automatic brk();     brk_i = 1;    @(negedge clk); brk_i = 0;    endtask
    task automatic tcall();   tcall_i = 1;  @(negedge clk); tcall_i = 0;  endtask
    task automatic reti();    reti_i = 1;   @(negedge clk); reti_i = 0;   endtask

    task automatic accept(input bit exp_g, input int exp_idx, input logic [15:0] exp_vec,
                          input string req);
        cpu_ready_i = 1; #1;
        chk(grant_o == exp_g, {req, " grant"}, 32'(grant_o), 32'(exp_g));
        if (exp_g) begin
            chk(grant_idx_o == 5'(exp_idx), {req, " index"}, 32'(grant_idx_o), 32'(exp_idx));
            chk(grant_vec_o == exp_vec, {req, " vector"}, 32'(grant_vec_o), 32'(exp_vec));
        end
        @(negedge clk); cpu_ready_i = 0;
    endtask

    task automatic t_reset();
        accept(0, 0, 0, "R1 reset");
        chk(me_o == 0, "R1 me", 32'(me_o), 0);
        chk(b_flag_o == 0, "R1 b", 32'(b_flag_o), 0);
    endtask

    task automatic t_mask();
        me_set();
        raise(16'h0004);
        accept(0, 0, 0, "R11 masked src2");
        en_write(0, 8'h04);
        accept(1, 2, 16'hFFC4, "R2 masked kept then granted");
        chk(me_o == 0, "R8 me cleared", 32'(me_o), 0);
        raise(16'h0004);
        accept(0, 0, 0, "R8 me off blocks");
        me_set();
        accept(1, 2, 16'hFFC4, "R2 still pending");
    endtask

    task automatic t_level();
        en_write(0, 8'hFF); en_write(1, 8'hFF);
        raise(16'h0015);
        me_set(); accept(1, 4, 16'hFFC8, "R3 level3 first");
        me_set(); accept(1, 2, 16'hFFC4, "R3 level2 next");
        me_set(); accept(1, 0, 16'hFFC0, "R3 level1 last");
        me_set(); accept(0, 0, 0, "R13 nothing left");
        me_clr();
    endtask

    task automatic t_tie();
        raise(16'h0003);
        me_set(); accept(1, 0, 16'hFFC0, "R4 tie src0");
        me_set(); accept(1, 1, 16'hFFC2, "R4 tie src1");
        raise(16'h8010);
        me_set(); accept(1, 4, 16'hFFC8, "R4 tie src4");
        me_set(); accept(1, 15, 16'hFFDE, "R6 src15 vector");
    endtask

    task automatic t_ready();
        raise(16'h0040);
        me_set(); #1;
        chk(grant_o == 0, "R13 no ready no grant", 32'(grant_o), 0);
        accept(1, 6, 16'hFFCC, "R13 src6");
        me_set(); accept(0, 0, 0, "R13 not regranted");
        me_clr();
    endtask

    task automatic t_swclr();
        raise(16'h0080);
        pend_clr_i = 16'h0080; @(negedge clk); pend_clr_i = '0;
        me_set(); accept(0, 0, 0, "R2 software clear");
        me_clr();
    endtask

    task automatic t_brk();
        brk();
        accept(1, 16, 16'hFFA0, "R12 break with me off");
        chk(b_flag_o == 1, "R7 b set", 32'(b_flag_o), 1);
        reti();
        chk(me_o == 0, "R10 reti restores 0", 32'(me_o), 0);
        tcall();
        chk(b_flag_o == 0, "R7 tcall clears b", 32'(b_flag_o), 0);
        raise(16'h0008); brk(); me_set();
        accept(1, 3, 16'hFFC6, "R5 hw beats break");
        chk(b_flag_o == 0, "R7 hw grant b=0", 32'(b_flag_o), 0);
        accept(1, 16, 16'hFFA0, "R5 break after");
        chk(b_flag_o == 1, "R7 b set again", 32'(b_flag_o), 1);
        reti();
        chk(me_o == 0, "R10 inner pop", 32'(me_o), 0);
        reti();
        chk(me_o == 1, "R10 outer pop", 32'(me_o), 1);
        me_clr();
    endtask

    task automatic t_nest();
        brk();
        accept(1, 16, 16'hFFA0, "R12 outer break");
        me_set(); raise(16'h0080);
        accept(1, 7, 16'hFFCE, "R9 nested grant");
        chk(me_o == 0, "R8 nested me cleared", 32'(me_o), 0);
        reti();
        chk(me_o == 1, "R10 nested pop 1", 32'(me_o), 1);
        reti();
        chk(me_o == 0, "R10 nested pop 0", 32'(me_o), 0);
    endtask

    task automatic t_high();
        en_write(1, 8'h00);
        raise(16'h8000);
        me_set(); accept(0, 0, 0, "R11 high masked");
        en_write(1, 8'h80);
        accept(1, 15, 16'hFFDE, "R11 high enabled");
        raise(16'h0004);
        me_set(); accept(1, 2, 16'hFFC4, "R11 low untouched");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset(); t_mask(); t_level(); t_tie(); t_ready();
        t_swclr(); t_brk(); t_nest(); t_high();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule